// File: doc/BRIEF.md
# Sampling-Based Long-Flow Steering Queue

This block sits in front of an egress link and sorts arriving packet descriptors into two classes that share a single descriptor store. Each descriptor carries a flow identifier and a short tag. For every arrival the block draws one pseudo-random trial with a programmable bias. Flows that collect enough successful trials are written into a small associative table of marked flows. From then on, every descriptor of a marked flow goes to the bulk (low-priority) queue. All other descriptors go to the mice (high-priority) queue.

Two marking modes are offered. In single-hit mode one success marks a flow. In double-hit mode a flow first becomes pending and is marked only on its second success. Once a flow is marked it stays in the bulk queue, so its packets never overtake one another.

The dequeue side is a single valid/ready port. It always presents the mice queue head when that queue is non-empty. Each queue has a runtime occupancy limit, and a descriptor that finds its queue at the limit is dropped and counted.

Top module: `elephant_steer`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0, both drop counters are 0, the marked-flow table is empty and the trial generator holds 16'hACE1.
- R2: The trial generator is a 16-bit shift register. Each step computes next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. It steps once per cycle with `in_valid`=1. A packet sees a success when the current state is unsigned-less than `cfg_thresh`. When `cfg_seed_load`=1 the state becomes `cfg_seed`, or 16'h0001 if the seed is zero, instead of stepping.
- R3: With `cfg_two_heads`=0, a success on a flow not in the table writes that flow into the table as marked, and that packet is classified bulk.
- R4: With `cfg_two_heads`=1, a success on a flow not in the table writes it as pending, and the packet is classified mice. A success on a pending flow marks it, and that packet is classified bulk.
- R5: A packet whose flow is marked in the table is classified bulk whatever its trial outcome.
- R6: A packet with no success whose flow is absent or pending is classified mice.
- R7: The table holds TBL_N flows. New flows are written at a round-robin pointer that starts at slot 0 and advances per write. A flow overwritten in this way is treated as unknown afterwards, and a flow never occupies two slots.
- R8: A packet is dropped when its queue's occupancy at the start of the cycle is at least min(limit, queue capacity). Capacity is SHORT_MAX for mice and LONG_MAX for bulk. The matching drop counter then rises by exactly 1 on the next cycle. Table and trial-generator updates happen even for a dropped packet.
- R9: While the mice queue is non-empty its head is presented, with `out_long`=0. Otherwise the bulk head is presented, with `out_long`=1. Each queue is first-in first-out. The presented head holds while `out_ready`=0 and no packet arrives.
- R10: An accepted packet becomes visible at the dequeue port on the cycle after its arrival. A head leaves on a cycle in which `out_valid` and `out_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_seed_load | input | 1 | Load `cfg_seed` into the trial generator |
| cfg_seed | input | 16 | Seed value |
| cfg_thresh | input | 16 | Success when generator state < this value |
| cfg_two_heads | input | 1 | 1 = double-hit marking mode |
| cfg_lim_short | input | LIM_W | Mice queue occupancy limit |
| cfg_lim_long | input | LIM_W | Bulk queue occupancy limit |
| in_valid | input | 1 | Descriptor arrival strobe |
| in_flow | input | FLOW_W | Flow identifier |
| in_tag | input | TAG_W | Descriptor tag |
| out_ready | input | 1 | Consumer accepts the presented head |
| out_valid | output | 1 | A head is presented |
| out_flow | output | FLOW_W | Flow identifier of the head |
| out_tag | output | TAG_W | Tag of the head |
| out_long | output | 1 | 1 = head comes from the bulk queue |
| drop_cnt_short | output | DROP_W | Mice queue drop count |
| drop_cnt_long | output | DROP_W | Bulk queue drop count |

## Verification
The trial draw and the table lookup happen within the arrival cycle. The queue entry, the `out_valid` change and any drop-counter step land on the following clock edge. The bench updates its reference model just after the edge that takes the packet. It compares the dequeue port one nanosecond after the next falling edge, which is the first point where that edge's effect is visible. A head is removed from the expected queues only when the sampled `out_valid` and `out_ready` are both high. Limit tests run with `out_ready` held low, so that occupancy at the start of the cycle matches the model's queue length exactly.

// File: rtl/elephant_pkg.sv
`timescale 1ns/1ps
package elephant_pkg;

    localparam logic [15:0] COIN_RESET = 16'hACE1;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_PEND = 2'd1,
        SLOT_MARK = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic bulk;
        logic promote;
        logic insert;
    } verdict_t;

    function automatic logic [15:0] coin_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [15:0] seed_fix(input logic [15:0] s);
        return (s == 16'h0000) ? 16'h0001 : s;
    endfunction

endpackage

// File: rtl/fs_coin.sv
`timescale 1ns/1ps
module fs_coin
    import elephant_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [15:0] seed,
    input  logic        step,
    output logic [15:0] state
);
    always_ff @(posedge clk) begin
        if (rst)       state <= COIN_RESET;
        else if (load) state <= seed_fix(seed);
        else if (step) state <= coin_step(state);
    end
endmodule

// File: rtl/fs_flow_table.sv
`timescale 1ns/1ps
module fs_flow_table
    import elephant_pkg::*;
#(
    parameter int FLOW_W = 12,
    parameter int TBL_N  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [FLOW_W-1:0] flow,
    input  logic              heads,
    input  logic              two_heads,
    output logic              bulk,
    output logic [TBL_N-1:0]  hit_vec
);
    localparam int IW = (TBL_N > 1) ? $clog2(TBL_N) : 1;

    logic [FLOW_W-1:0] ids [TBL_N];
    slot_state_e       st  [TBL_N];
    logic [IW-1:0]     rr;
    logic [IW-1:0]     hit_idx;
    logic              hit_any;
    logic              hit_mark;
    verdict_t          v;

    for (genvar i = 0; i < TBL_N; i++) begin : g_cmp
        assign hit_vec[i] = (st[i] != SLOT_FREE) && (ids[i] == flow);
    end

    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < TBL_N; i++) begin
            if (hit_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = IW'(i);
            end
        end
        hit_mark  = hit_any && (st[hit_idx] == SLOT_MARK);
        v.bulk    = hit_mark || (heads && (hit_any || !two_heads));
        v.promote = hit_any && !hit_mark && heads;
        v.insert  = !hit_any && heads;
    end

    assign bulk = v.bulk;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr <= '0;
            for (int i = 0; i < TBL_N; i++) begin
                st[i]  <= SLOT_FREE;
                ids[i] <= '0;
            end
        end else if (en) begin
            if (v.promote) st[hit_idx] <= SLOT_MARK;
            if (v.insert) begin
                ids[rr] <= flow;
                st[rr]  <= two_heads ? SLOT_PEND : SLOT_MARK;
                rr      <= (rr == IW'(TBL_N - 1)) ? '0 : rr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fs_dual_queue.sv
`timescale 1ns/1ps
module fs_dual_queue #(
    parameter int W         = 20,
    parameter int SHORT_MAX = 10,
    parameter int LONG_MAX  = 290,
    parameter int LIM_W     = 9,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              push_bulk,
    input  logic [W-1:0]      push_data,
    input  logic [LIM_W-1:0]  lim_mice,
    input  logic [LIM_W-1:0]  lim_bulk,
    input  logic              pop,
    output logic              head_valid,
    output logic              head_bulk,
    output logic [W-1:0]      head_data,
    output logic [DROP_W-1:0] drop_mice,
    output logic [DROP_W-1:0] drop_bulk
);
    localparam int TOTAL = SHORT_MAX + LONG_MAX;
    localparam int AW    = $clog2(TOTAL);
    localparam int MAXD  = (SHORT_MAX > LONG_MAX) ? SHORT_MAX : LONG_MAX;
    localparam int PW    = $clog2(MAXD + 1);

    logic [W-1:0]      mem [TOTAL];
    logic [LIM_W-1:0]  lim    [2];
    logic [PW-1:0]     cnt_a  [2];
    logic [PW-1:0]     wp_a   [2];
    logic [AW-1:0]     rd_a   [2];
    logic [DROP_W-1:0] drop_a [2];
    logic [1:0]        acc;
    logic              sel_q;

    assign lim[0] = lim_mice;
    assign lim[1] = lim_bulk;

    assign sel_q      = (cnt_a[0] == '0);
    assign head_valid = (cnt_a[0] != '0) || (cnt_a[1] != '0);
    assign head_bulk  = sel_q;
    assign head_data  = mem[rd_a[sel_q]];

    for (genvar q = 0; q < 2; q++) begin : g_q
        localparam int DEP  = (q == 0) ? SHORT_MAX : LONG_MAX;
        localparam int BASE = (q == 0) ? 0 : SHORT_MAX;

        logic [PW-1:0]     wp, rp, cnt, lim_eff;
        logic [DROP_W-1:0] dc;
        logic              mine, deq;

        assign lim_eff = (int'(lim[q]) > DEP) ? PW'(DEP) : PW'(lim[q]);
        assign mine    = push && (push_bulk == 1'(q));
        assign acc[q]  = mine && (cnt < lim_eff);
        assign deq     = pop && (sel_q == 1'(q));

        always_ff @(posedge clk) begin
            if (rst) begin
                wp  <= '0;
                rp  <= '0;
                cnt <= '0;
                dc  <= '0;
            end else begin
                if (acc[q]) wp <= (wp == PW'(DEP - 1)) ? '0 : wp + 1'b1;
                if (deq)    rp <= (rp == PW'(DEP - 1)) ? '0 : rp + 1'b1;
                case ({acc[q], deq})
                    2'b10:   cnt <= cnt + 1'b1;
                    2'b01:   cnt <= cnt - 1'b1;
                    default: cnt <= cnt;
                endcase
                if (mine && !acc[q]) dc <= dc + 1'b1;
            end
        end

        assign cnt_a[q]  = cnt;
        assign wp_a[q]   = wp;
        assign rd_a[q]   = AW'(BASE) + AW'(rp);
        assign drop_a[q] = dc;
    end

    always_ff @(posedge clk) begin
        if (acc[0]) mem[AW'(wp_a[0])]            <= push_data;
        if (acc[1]) mem[AW'(SHORT_MAX) + AW'(wp_a[1])] <= push_data;
    end

    assign drop_mice = drop_a[0];
    assign drop_bulk = drop_a[1];
endmodule

// File: rtl/elephant_steer.sv
`timescale 1ns/1ps
module elephant_steer
    import elephant_pkg::*;
#(
    parameter int FLOW_W    = 12,
    parameter int TAG_W     = 8,
    parameter int TBL_N     = 16,
    parameter int SHORT_MAX = 10,
    parameter int LONG_MAX  = 290,
    parameter int DROP_W    = 16,
    localparam int LIM_W    = $clog2(((SHORT_MAX > LONG_MAX) ? SHORT_MAX : LONG_MAX) + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_seed_load,
    input  logic [15:0]       cfg_seed,
    input  logic [15:0]       cfg_thresh,
    input  logic              cfg_two_heads,
    input  logic [LIM_W-1:0]  cfg_lim_short,
    input  logic [LIM_W-1:0]  cfg_lim_long,
    input  logic              in_valid,
    input  logic [FLOW_W-1:0] in_flow,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [FLOW_W-1:0] out_flow,
    output logic [TAG_W-1:0]  out_tag,
    output logic              out_long,
    output logic [DROP_W-1:0] drop_cnt_short,
    output logic [DROP_W-1:0] drop_cnt_long
);
    localparam int DW = FLOW_W + TAG_W;

    logic [15:0]      coin;
    logic             heads;
    logic             is_bulk;
    logic [TBL_N-1:0] tbl_hit;
    logic [DW-1:0]    head_data;

    fs_coin u_coin (
        .clk   (clk),
        .rst   (rst),
        .load  (cfg_seed_load),
        .seed  (cfg_seed),
        .step  (in_valid),
        .state (coin)
    );

    assign heads = (coin < cfg_thresh);

    fs_flow_table #(.FLOW_W(FLOW_W), .TBL_N(TBL_N)) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .en        (in_valid),
        .flow      (in_flow),
        .heads     (heads),
        .two_heads (cfg_two_heads),
        .bulk      (is_bulk),
        .hit_vec   (tbl_hit)
    );

    fs_dual_queue #(
        .W(DW), .SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX),
        .LIM_W(LIM_W), .DROP_W(DROP_W)
    ) u_q (
        .clk        (clk),
        .rst        (rst),
        .push       (in_valid),
        .push_bulk  (is_bulk),
        .push_data  ({in_flow, in_tag}),
        .lim_mice   (cfg_lim_short),
        .lim_bulk   (cfg_lim_long),
        .pop        (out_valid && out_ready),
        .head_valid (out_valid),
        .head_bulk  (out_long),
        .head_data  (head_data),
        .drop_mice  (drop_cnt_short),
        .drop_bulk  (drop_cnt_long)
    );

    assign out_flow = head_data[DW-1:TAG_W];
    assign out_tag  = head_data[TAG_W-1:0];
endmodule

// File: rtl/elephant_steer_chk.sv
`timescale 1ns/1ps
module elephant_steer_chk #(
    parameter int FLOW_W = 12,
    parameter int TAG_W  = 8,
    parameter int TBL_N  = 16,
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [FLOW_W-1:0] out_flow,
    input logic [TAG_W-1:0]  out_tag,
    input logic [DROP_W-1:0] drop_cnt_short,
    input logic [DROP_W-1:0] drop_cnt_long,
    input logic [TBL_N-1:0]  tbl_hit
);
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    assert_drop_step_short_R8: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt_short == $past(drop_cnt_short)) ||
        (drop_cnt_short == $past(drop_cnt_short) + 1'b1));

    assert_drop_step_long_R8: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt_long == $past(drop_cnt_long)) ||
        (drop_cnt_long == $past(drop_cnt_long) + 1'b1));

    assert_single_hit_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> $onehot0(tbl_hit));

    assert_head_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !in_valid) |=>
        (out_valid && $stable(out_flow) && $stable(out_tag)));

    assert_enqueue_visible_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !out_valid) |=>
        (out_valid || (drop_cnt_short != $past(drop_cnt_short)) ||
         (drop_cnt_long != $past(drop_cnt_long))));
endmodule

bind elephant_steer elephant_steer_chk #(
    .FLOW_W(FLOW_W), .TAG_W(TAG_W), .TBL_N(TBL_N), .DROP_W(DROP_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_flow       (out_flow),
    .out_tag        (out_tag),
    .drop_cnt_short (drop_cnt_short),
    .drop_cnt_long  (drop_cnt_long),
    .tbl_hit        (tbl_hit)
);

// File: tb/elephant_steer_bench.sv
`timescale 1ns/1ps
module elephant_steer_bench;
    localparam int FW = 12, TW = 8, TN = 16, SMAX = 10, LMAX = 290, LW = 9;

    typedef struct packed { logic [FW-1:0] f; logic [TW-1:0] t; } item_t;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_seed_load = 1'b0, cfg_two_heads = 1'b0;
    logic [15:0] cfg_seed = '0, cfg_thresh = '0;
    logic [LW-1:0] cfg_lim_short = LW'(SMAX), cfg_lim_long = LW'(LMAX);
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic [FW-1:0] in_flow = '0;
    logic [TW-1:0] in_tag = '0;
    logic out_valid, out_long;
    logic [FW-1:0] out_flow;
    logic [TW-1:0] out_tag;
    logic [15:0] drop_cnt_short, drop_cnt_long;

    always #2 clk = ~clk;

    elephant_steer u_elephant_steer (
        .clk(clk), .rst(rst), .cfg_seed_load(cfg_seed_load), .cfg_seed(cfg_seed),
        .cfg_thresh(cfg_thresh), .cfg_two_heads(cfg_two_heads),
        .cfg_lim_short(cfg_lim_short), .cfg_lim_long(cfg_lim_long),
        .in_valid(in_valid), .in_flow(in_flow), .in_tag(in_tag),
        .out_ready(out_ready), .out_valid(out_valid), .out_flow(out_flow),
        .out_tag(out_tag), .out_long(out_long),
        .drop_cnt_short(drop_cnt_short), .drop_cnt_long(drop_cnt_long)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [15:0]   m_coin;
    logic [FW-1:0] m_ids [TN];
    int            m_st  [TN];
    int            m_rr, m_drop_s, m_drop_l;
    item_t         q_s[$], q_l[$];
    logic [TW-1:0] tag_ctr = '0;

    function automatic logic [15:0] ref_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int clampv(input int v, input int m);
        return (v > m) ? m : v;
    endfunction

    task automatic model_reset();
        m_coin = 16'hACE1; m_rr = 0; m_drop_s = 0; m_drop_l = 0;
        for (int i = 0; i < TN; i++) begin m_st[i] = 0; m_ids[i] = '0; end
        q_s.delete(); q_l.delete();
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // model of one arrival; states: 0 free, 1 pending, 2 marked
    task automatic model_arrive(input logic [FW-1:0] f, input logic [TW-1:0] t);
        bit hd, bulk;
        int hit;
        item_t it;
        hd = (m_coin < cfg_thresh);
        m_coin = ref_step(m_coin);
        hit = -1;
        for (int i = 0; i < TN; i++) if (m_st[i] != 0 && m_ids[i] == f) hit = i;
        bulk = (hit >= 0 && m_st[hit] == 2) || (hd && (hit >= 0 || !cfg_two_heads));
        if (hit >= 0 && m_st[hit] == 1 && hd) m_st[hit] = 2;
        if (hit < 0 && hd) begin
            m_ids[m_rr] = f;
            m_st[m_rr] = cfg_two_heads ? 1 : 2;
            m_rr = (m_rr + 1) % TN;
        end
        it.f = f; it.t = t;
        if (bulk) begin
            if (q_l.size() >= clampv(int'(cfg_lim_long), LMAX)) m_drop_l++;
            else q_l.push_back(it);
        end else begin
            if (q_s.size() >= clampv(int'(cfg_lim_short), SMAX)) m_drop_s++;
            else q_s.push_back(it);
        end
    endtask

    task automatic send(input logic [FW-1:0] f);
        tag_ctr = tag_ctr + 1'b1;
        in_valid = 1'b1; in_flow = f; in_tag = tag_ctr;
        @(posedge clk);
        model_arrive(f, tag_ctr);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic load_seed(input logic [15:0] s);
        cfg_seed = s; cfg_seed_load = 1'b1;
        @(posedge clk);
        m_coin = (s == 16'h0) ? 16'h0001 : s;
        @(negedge clk);
        cfg_seed_load = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        model_reset();
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor: samples 1 ns after each falling edge
    always begin
        item_t e;
        bit ev;
        @(negedge clk); #1;
        if (!rst && !done) begin
            ev = (q_s.size() + q_l.size()) > 0;
            if (out_valid || ev) begin
                if (out_valid !== ev) begin
                    check(1'b0, "R10", "out_valid", int'(out_valid), int'(ev));
                end else begin
                    e = (q_s.size() > 0) ? q_s[0] : q_l[0];
                    check(out_flow == e.f, cur_req, "out_flow", int'(out_flow), int'(e.f));
                    check(out_tag == e.t, cur_req, "out_tag", int'(out_tag), int'(e.t));
                    check(out_long == (q_s.size() == 0), "R9", "out_long",
                          int'(out_long), int'(q_s.size() == 0));
                    if (out_ready) begin
                        if (q_s.size() > 0) void'(q_s.pop_front());
                        else void'(q_l.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk); #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(drop_cnt_short == 0 && drop_cnt_long == 0, "R1", "drop counters",
              int'(drop_cnt_short) + int'(drop_cnt_long), 0);
        @(negedge clk);

        // R6: no successes, everything stays in the mice queue
        cur_req = "R6"; out_ready = 1'b1; cfg_thresh = 16'h0000;
        for (int i = 0; i < 6; i++) send(FW'(1 + i % 3));
        idle(3);

        // R3 then R5: mark flow 0x100, later packets stay bulk with no success
        cur_req = "R3"; cfg_thresh = 16'hFFFF;
        send(12'h100);
        cur_req = "R5"; cfg_thresh = 16'h0000;
        for (int i = 0; i < 3; i++) send(12'h100);
        send(12'h101);
        idle(4);

        // R2: seeded generator, mixed outcomes, zero seed case
        cur_req = "R2"; cfg_thresh = 16'h4000;
        load_seed(16'h1234);
        for (int i = 0; i < 40; i++) send(FW'(16 + i % 6));
        load_seed(16'h0000);
        for (int i = 0; i < 20; i++) send(FW'(40 + i % 5));
        idle(4);

        // R4: double-hit marking
        do_reset();
        cur_req = "R4"; cfg_two_heads = 1'b1; cfg_thresh = 16'hFFFF;
        for (int i = 0; i < 3; i++) send(12'h200);
        cfg_thresh = 16'h3000;
        for (int i = 0; i < 30; i++) send(FW'(64 + i % 4));
        idle(4);
        cfg_two_heads = 1'b0;

        // R7: seventeen marks overwrite slot 0
        do_reset();
        cur_req = "R7"; cfg_thresh = 16'hFFFF;
        for (int i = 0; i < 17; i++) send(FW'(12'h300 + i));
        cfg_thresh = 16'h0000;
        send(12'h300); send(12'h301); send(12'h310);
        idle(4);

        // R8: limits, drops, clamping to capacity
        do_reset();
        cur_req = "R8"; out_ready = 1'b0; cfg_thresh = 16'h0000;
        cfg_lim_short = 9'd3;
        for (int i = 0; i < 5; i++) send(FW'(12'h400 + i));
        idle(1); #1;
        check(drop_cnt_short == 16'd2, "R8", "short drops at limit 3", int'(drop_cnt_short), 2);
        cfg_lim_long = 9'd2; cfg_thresh = 16'hFFFF;
        for (int i = 0; i < 4; i++) send(FW'(12'h410 + i));
        idle(1); #1;
        check(int'(drop_cnt_long) == m_drop_l, "R8", "long drops at limit 2",
              int'(drop_cnt_long), m_drop_l);
        out_ready = 1'b1; idle(12); out_ready = 1'b0;
        cfg_lim_short = 9'h1FF; cfg_thresh = 16'h0000;
        for (int i = 0; i < 12; i++) send(FW'(12'h420 + i));
        idle(1); #1;
        check(int'(drop_cnt_short) == m_drop_s, "R8", "short drops clamped to capacity",
              int'(drop_cnt_short), m_drop_s);
        check(m_drop_s == 4, "R8", "model short drops", m_drop_s, 4);
        out_ready = 1'b1; idle(16);
        cfg_lim_short = LW'(SMAX); cfg_lim_long = LW'(LMAX);

        // R9: bulk queued before mice, mice must leave first
        cur_req = "R9"; out_ready = 1'b0; cfg_thresh = 16'hFFFF;
        for (int i = 0; i < 3; i++) send(FW'(12'h500 + i));
        cfg_thresh = 16'h0000;
        send(12'h510); send(12'h511);
        idle(2);
        out_ready = 1'b1;
        idle(10);

        // R10: single packet, visible on the next cycle
        cur_req = "R10";
        send(12'h600);
        idle(3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule